// File: doc/BRIEF.md
# Programmable UART Baud Rate Generator

This block produces the timing strobes for a UART. A 16-bit divisor register sets the reload period of a free-running counter. The counter wraps once every divisor + 1 clock cycles, and each wrap gives one oversampling strobe (`sample_tick`). A small prescaler counts these strobes. On every 16th strobe, or on every 4th when the fast-oversampling mode bit is set, it gives a one-per-bit strobe (`baud_tick`). The transmit and receive shifters use these two strobes as clock enables.

Software programs the block through a one-word write port. Select 0 writes the divisor and select 1 writes the mode bit, which is write data bit 0. A divisor write clears both counters at once, so the new rate starts from a whole period and does not wait for the old period to run out. A mode write clears only the prescaler.

A two-state controller gates the counting. In `BG_OFF` both counters are held at zero and no strobe is produced. The controller moves `BG_OFF -> BG_RUN` on an edge that samples `enable` high. It moves `BG_RUN -> BG_OFF` on an edge that samples `enable` low. While in `BG_RUN`, a low `enable` stops counting in that same cycle.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 0, the mode is 0 (16x), both counters are zero and both strobes are low. With `enable` high, the first `baud_tick` is seen 16 cycles after the edge that enters `BG_RUN`.
- R2: `sample_tick` is a one-cycle pulse. It repeats every divisor + 1 cycles, and the same edge that wraps the counter registers it.
- R3: With mode 0, `baud_tick` repeats every 16 × (divisor + 1) cycles.
- R4: With mode 1, `baud_tick` repeats every 4 × (divisor + 1) cycles.
- R5: A divisor write (`cfg_sel`=0, `cfg_wdata`[15:0]) clears both counters on its edge. The first `baud_tick` is then seen R × (divisor + 1) cycles after that edge, where R is 16 or 4.
- R6: A mode write (`cfg_sel`=1, `cfg_wdata`[0]) clears only the prescaler. When it lands on the edge right after a `sample_tick` edge and the divisor is at least 1, the next `baud_tick` comes R × (divisor + 1) − 1 cycles after the write edge.
- R7: While `enable` is low, no strobe is produced and the counters stay at zero. The first `baud_tick` after `enable` returns comes R × (divisor + 1) cycles after the `BG_OFF -> BG_RUN` edge.
- R8: With divisor 65535, `sample_tick` repeats every 65536 cycles. With divisor 0 in mode 1, `baud_tick` repeats every 4 cycles.
- R9: With divisor 25 in mode 0, `baud_tick` repeats every 416 cycles.
- R10: Every `baud_tick` coincides with a `sample_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (instruction clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low holds counters at zero |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = divisor, 1 = mode bit |
| cfg_wdata | input | 16 | Write data; mode is bit 0 |
| sample_tick | output | 1 | Oversampling strobe, one cycle per counter wrap |
| baud_tick | output | 1 | One strobe per bit period |

## Verification
The bench drives the divisor to both extremes. A counter that compares at the wrong value, or is one bit too narrow, gives periods that are off by one, or in the 65535 case collapses to a short period. It writes the divisor in the middle of a period. A design that waited for the old wrap would give a first tick later than R × (divisor + 1). It times a mode write against a known counter phase, which catches a prescaler that is not cleared or a divisor counter that is cleared by mistake. It also drops `enable` while ticks are running, because a design that keeps counting would strobe during that time or restart at the wrong phase.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic {
        BG_OFF = 1'b0,
        BG_RUN = 1'b1
    } bg_state_e;

    localparam int unsigned CFG_SEL_DIV  = 0;
    localparam int unsigned CFG_SEL_MODE = 1;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [DIV_W-1:0] cfg_wdata,
    output logic [DIV_W-1:0] div_q,
    output logic             mode_q,
    output logic             div_wr,
    output logic             mode_wr
);
    assign div_wr  = cfg_we && (cfg_sel == 1'(baud_pkg::CFG_SEL_DIV));
    assign mode_wr = cfg_we && (cfg_sel == 1'(baud_pkg::CFG_SEL_MODE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            if (div_wr)  div_q  <= cfg_wdata;
            if (mode_wr) mode_q <= cfg_wdata[0];
        end
    end

    // R5
    div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (div_q == $past(cfg_wdata)));
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_q,
    output logic             wrap
);
    logic [DIV_W-1:0] cnt_q;

    assign wrap = run && !clr && (cnt_q == div_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == div_q) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_q);

    // R5
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int unsigned NORM_OSR = 16,
    parameter int unsigned FAST_OSR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic mode,
    input  logic wrap,
    output logic baud_hit
);
    localparam int unsigned PRE_W = $clog2(NORM_OSR);
    localparam logic [PRE_W-1:0] NORM_LAST = PRE_W'(NORM_OSR - 1);
    localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'(FAST_OSR - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    assign last     = mode ? FAST_LAST : NORM_LAST;
    assign baud_hit = run && !clr && wrap && (pre_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || clr) begin
            pre_q <= '0;
        end else if (wrap) begin
            pre_q <= (pre_q == last) ? '0 : pre_q + 1'b1;
        end
    end

    // R6
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));

    // R4
    pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (pre_q <= last));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned NORM_OSR = 16,
    parameter int unsigned FAST_OSR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [DIV_W-1:0] cfg_wdata,
    output logic             sample_tick,
    output logic             baud_tick
);
    import baud_pkg::*;

    bg_state_e        state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic             mode_q;
    logic             div_wr, mode_wr;
    logic             run, wrap, baud_hit;

    baud_cfg_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .div_q(div_q), .mode_q(mode_q),
        .div_wr(div_wr), .mode_wr(mode_wr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BG_OFF: if (enable)  state_d = BG_RUN;
            BG_RUN: if (!enable) state_d = BG_OFF;
            default:             state_d = BG_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BG_OFF;
        else        state_q <= state_d;
    end

    assign run = (state_q == BG_RUN) && enable;

    baud_div_counter #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(div_wr),
        .div_q(div_q), .wrap(wrap)
    );

    baud_prescaler #(.NORM_OSR(NORM_OSR), .FAST_OSR(FAST_OSR)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(div_wr || mode_wr),
        .mode(mode_q), .wrap(wrap), .baud_hit(baud_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_tick <= 1'b0;
            baud_tick   <= 1'b0;
        end else begin
            sample_tick <= wrap;
            baud_tick   <= baud_hit;
        end
    end

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sample_tick && !baud_tick));

    // R7
    off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == BG_OFF));

    // R10
    baud_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sample_tick);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        sample_tick, baud_tick;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .sample_tick(sample_tick), .baud_tick(baud_tick)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int exp_period(input int d, input bit m);
        return (m ? 4 : 16) * (d + 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a write now; caller stands at a negedge. Returns just after the write edge.
    task automatic drive_cfg(input bit sel, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic wr(input bit sel, input logic [15:0] d);
        @(negedge clk);
        drive_cfg(sel, d);
    endtask

    // Posedges until baud_tick is seen high at a negedge.
    task automatic wait_baud(output int n);
        n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (baud_tick || n > 100000) break;
        end
    endtask

    task automatic wait_sample(output int n);
        n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (sample_tick || n > 100000) break;
        end
    endtask

    initial begin
        int n, d, seen;
        bit m;
        int unsigned seed;
        seed = $urandom(32'h5EED_0B0D);

        // R1: reset state
        #23;
        check("R1 sample low in reset", int'(sample_tick), 0);
        check("R1 baud low in reset", int'(baud_tick), 0);
        @(negedge clk); rst_n = 1'b1;
        enable = 1'b1;
        @(posedge clk); #1;              // edge entering BG_RUN
        wait_baud(n);
        check("R1 first baud after enable, default divisor", n, 16);

        // R8: divisor 0 fast mode
        wr(1'b1, 16'h0001);
        wr(1'b0, 16'd0);
        wait_baud(n); check("R8 div0 fast first", n, 4);
        wait_baud(n); check("R8 div0 fast period", n, 4);

        // R9: 25 in mode 0
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'd25);
        wait_baud(n); check("R9 div25 first", n, 416);
        wait_baud(n); check("R9 div25 period", n, 416);

        // R2: sample period and one-cycle width
        wait_sample(n); check("R2 sample period", n, 26);
        @(posedge clk); @(negedge clk);
        check("R2 sample one cycle wide", int'(sample_tick), 0);

        // R5: mid-period divisor write restarts
        repeat (37) @(posedge clk);
        wr(1'b0, 16'd7);
        wait_baud(n); check("R5 restart after mid-period write", n, 128);

        // R6: mode write right after a sample tick
        wait_sample(n);
        drive_cfg(1'b1, 16'h0001);
        wait_baud(n); check("R6 mode write phase", n, exp_period(7, 1'b1) - 1);
        wait_baud(n); check("R4 fast period after mode write", n, 32);

        // R7: disable holds quiet
        @(negedge clk); enable = 1'b0;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); @(negedge clk);
            if (sample_tick || baud_tick) seen++;
        end
        check("R7 no strobe while disabled", seen, 0);
        enable = 1'b1;
        @(posedge clk); #1;
        wait_baud(n); check("R7 first baud after re-enable", n, 32);

        // Random divisor/mode sweep: R3, R4, R5, R10
        for (int k = 0; k < 12; k++) begin
            d = int'($urandom % 40);
            m = 1'($urandom % 2);
            wr(1'b1, {15'd0, m});
            repeat (int'($urandom % 9)) @(posedge clk);
            wr(1'b0, 16'(d));
            wait_baud(n);
            check("R5 random first baud", n, exp_period(d, m));
            check("R10 sample with baud", int'(sample_tick), 1);
            wait_baud(n);
            check(m ? "R4 random period" : "R3 random period", n, exp_period(d, m));
        end

        // R8: maximum divisor sample period
        wr(1'b0, 16'hFFFF);
        wait_sample(n); check("R8 max divisor sample period", n, 65536);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule